// File: doc/BRIEF.md
# Video Clock Source Divider Tree

This block builds a small tree of clock enables for a video output path. Every clock is modelled as a one-cycle enable pulse in a single reference clock domain. A 3-bit select picks one of several source enables: two video PLL outputs and fixed dividers of a reference PLL. A programmable base divider with an 8-bit field counts the pulses of the chosen source. The field holds the divide ratio minus one. Each time the count completes, the divider emits one base enable.

Four branch dividers count base enables and derive the encoder, front-end, pixel-pipe and transmitter-pixel enables. Each branch has a compact ratio code and its own gate bit.

Reprogramming is safe by construction. The source select and the base ratio are taken only while the base run bit is low. While the run bit is low, every counter is held at zero, so turning the divider back on always starts with a clean phase.

Top module: `vclk_div_tree`

## Requirements
- R1: After a synchronous reset, `base_tick_o` and all `br_tick_o` bits are low, and every counter starts from zero.
- R2: The select code picks the source enable by index. Codes 0 to 5 pick `src_en_i[0]` to `src_en_i[5]`. Code 6 also picks `src_en_i[4]`. Code 7 picks nothing, so it never produces a base enable.
- R3: With the ratio field at N-1 (N from 1 to 256) and the run bit high, `base_tick_o` pulses once for every N selected source pulses. The pulse appears in the cycle after the clock edge that samples the N-th pulse. After the run bit rises, counting starts from zero.
- R4: While `base_run_i` is low, the base counter holds at zero and `base_tick_o` stays low. The select and ratio inputs are captured only in cycles where the run bit is low. Changes made while the run bit is high have no effect until the run bit is next low.
- R5: A branch counts base enables. Its 4-bit code gives the ratio: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 12, and codes 5 to 15 give 1. The branch pulse appears one cycle after the base pulse that completes its count.
- R6: A branch whose gate bit is low emits no pulses and holds its counter at zero. When the gate returns high, the branch counts again from zero.
- R7: All branch counters are cleared in every cycle where `base_run_i` is low.
- R8: Branch index 0 is the encoder, 1 the front end, 2 the pixel pipe and 3 the transmitter pixel. Branch b takes its code from `br_code_i[4b+3:4b]` and its gate from `br_gate_i[b]`. The branches run independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_i | input | 6 | Source enables, one bit per source |
| base_run_i | input | 1 | Base divider run bit |
| src_sel_i | input | 3 | Source select code |
| base_ratio_m1_i | input | 8 | Base divide ratio minus one |
| br_code_i | input | 16 | Four 4-bit branch ratio codes |
| br_gate_i | input | 4 | Branch gate bits |
| base_tick_o | output | 1 | Base clock enable |
| br_tick_o | output | 4 | Branch clock enables |

## Verification
The tree is driven in three ways:
- With every source pulsing every cycle, the tick counts over fixed windows show the exact base and branch ratios, including an out-of-range branch code.
- With only source 4 active, select codes 6 and 0 are told apart, which shows that the alias code works and that the other sources are not picked.
- With random source enables, the select mapping is exercised, because each source then has a different pulse pattern.

Directed windows also cover the following:
- a select or ratio change made while running is ignored;
- select code 7 produces nothing;
- a gated branch stays silent;
- a short drop of the run bit clears a half-finished branch count.

// File: rtl/vclk_pkg.sv
package vclk_pkg;
  localparam int SEL_W      = 3;
  localparam int NUM_SRC    = 6;
  localparam int ALIAS_CODE = 6;
  localparam int ALIAS_SRC  = 4;
  localparam int RATIO_W    = 8;
  localparam int NUM_BR     = 4;
  localparam int CODE_W     = 4;
  localparam int BR_MAX     = 12;
  localparam int BR_CNT_W   = $clog2(BR_MAX);

  // Branch code to terminal count (ratio minus one); unknown codes divide by one.
  function automatic logic [BR_CNT_W-1:0] br_last(input logic [CODE_W-1:0] code);
    case (code)
      CODE_W'(0): br_last = BR_CNT_W'(0);
      CODE_W'(1): br_last = BR_CNT_W'(1);
      CODE_W'(2): br_last = BR_CNT_W'(3);
      CODE_W'(3): br_last = BR_CNT_W'(5);
      CODE_W'(4): br_last = BR_CNT_W'(11);
      default:    br_last = BR_CNT_W'(0);
    endcase
  endfunction
endpackage

// File: rtl/vclk_src_sel.sv
module vclk_src_sel
  import vclk_pkg::*;
#(
  parameter int SW   = SEL_W,
  parameter int NSRC = NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run_i,
  input  logic [SW-1:0]   sel_i,
  input  logic [NSRC-1:0] src_en_i,
  output logic            pulse_o
);
  logic [SW-1:0] sel_q;

  // Select is only taken while the base divider is stopped.
  always_ff @(posedge clk) begin
    if (rst)         sel_q <= '0;
    else if (!run_i) sel_q <= sel_i;
  end

  always_comb begin
    pulse_o = 1'b0;
    for (int i = 0; i < NSRC; i++)
      if (sel_q == SW'(i)) pulse_o = src_en_i[i];
    if (sel_q == SW'(ALIAS_CODE)) pulse_o = src_en_i[ALIAS_SRC];
  end

  p_sel_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    run_i |=> $stable(sel_q));
endmodule

// File: rtl/vclk_base_div.sv
module vclk_base_div
  import vclk_pkg::*;
#(
  parameter int RW = RATIO_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic [RW-1:0] ratio_m1_i,
  input  logic          pulse_i,
  output logic          tick_o
);
  logic [RW-1:0] ratio_q;
  logic [RW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= '0;
      cnt     <= '0;
      tick_o  <= 1'b0;
    end else if (!run_i) begin
      ratio_q <= ratio_m1_i;
      cnt     <= '0;
      tick_o  <= 1'b0;
    end else if (pulse_i) begin
      if (cnt == ratio_q) begin
        cnt    <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (!tick_o && cnt == '0));
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= ratio_q);
  p_ratio_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    run_i |=> $stable(ratio_q));
endmodule

// File: rtl/vclk_branch_div.sv
module vclk_branch_div
  import vclk_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_i,
  input  logic          gate_i,
  input  logic [CW-1:0] code_i,
  input  logic          base_tick_i,
  output logic          tick_o
);
  logic [BR_CNT_W-1:0] cnt;
  logic [BR_CNT_W-1:0] last;

  assign last = br_last(code_i);

  always_ff @(posedge clk) begin
    if (rst || !run_i || !gate_i) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else if (base_tick_i) begin
      if (cnt >= last) begin
        cnt    <= '0;
        tick_o <= 1'b1;
      end else begin
        cnt    <= cnt + 1'b1;
        tick_o <= 1'b0;
      end
    end else begin
      tick_o <= 1'b0;
    end
  end

  p_gate_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !gate_i |=> (!tick_o && cnt == '0));
  p_cleared_off_r7: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> cnt == '0);
  p_tick_after_base_r5: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(base_tick_i));
endmodule

// File: rtl/vclk_div_tree.sv
module vclk_div_tree
  import vclk_pkg::*;
#(
  parameter int SW   = SEL_W,
  parameter int NSRC = NUM_SRC,
  parameter int RW   = RATIO_W,
  parameter int NBR  = NUM_BR,
  parameter int CW   = CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              base_run_i,
  input  logic [SW-1:0]     src_sel_i,
  input  logic [RW-1:0]     base_ratio_m1_i,
  input  logic [NBR*CW-1:0] br_code_i,
  input  logic [NBR-1:0]    br_gate_i,
  output logic              base_tick_o,
  output logic [NBR-1:0]    br_tick_o
);
  logic src_pulse;

  vclk_src_sel #(.SW(SW), .NSRC(NSRC)) u_sel (
    .clk(clk), .rst(rst), .run_i(base_run_i), .sel_i(src_sel_i),
    .src_en_i(src_en_i), .pulse_o(src_pulse)
  );

  vclk_base_div #(.RW(RW)) u_base (
    .clk(clk), .rst(rst), .run_i(base_run_i), .ratio_m1_i(base_ratio_m1_i),
    .pulse_i(src_pulse), .tick_o(base_tick_o)
  );

  for (genvar b = 0; b < NBR; b++) begin : g_br
    vclk_branch_div #(.CW(CW)) u_br (
      .clk(clk), .rst(rst), .run_i(base_run_i), .gate_i(br_gate_i[b]),
      .code_i(br_code_i[b*CW +: CW]), .base_tick_i(base_tick_o),
      .tick_o(br_tick_o[b])
    );
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!base_tick_o && br_tick_o == '0));
endmodule

// File: tb/vclk_div_tree_tb.sv
module vclk_div_tree_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] src_en_i = '0;
  logic       base_run_i = 1'b0;
  logic [2:0] src_sel_i = '0;
  logic [7:0] base_ratio_m1_i = '0;
  logic [15:0] br_code_i = '0;
  logic [3:0] br_gate_i = '0;
  logic       base_tick_o;
  logic [3:0] br_tick_o;

  int checks = 0, errors = 0;
  int src_mode = 0;
  string cur_tag = "R1";
  int base_seen = 0;
  int br_seen [4];

  // reference model state
  int  m_sel = 0, m_ratio = 0, m_cnt = 0;
  bit  m_base = 0;
  int  m_bcnt [4];
  bit  m_btick [4];

  always #2 clk = ~clk;

  vclk_div_tree u_dut (
    .clk(clk), .rst(rst), .src_en_i(src_en_i), .base_run_i(base_run_i),
    .src_sel_i(src_sel_i), .base_ratio_m1_i(base_ratio_m1_i),
    .br_code_i(br_code_i), .br_gate_i(br_gate_i),
    .base_tick_o(base_tick_o), .br_tick_o(br_tick_o)
  );

  function automatic int ratio_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 6;
      4: return 12;
      default: return 1;
    endcase
  endfunction

  function automatic bit pick(input int sel, input logic [5:0] s);
    if (sel == 7) return 1'b0;
    if (sel == 6) return s[4];
    return s[sel];
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model, evaluated at each rising edge from the sampled inputs
  always @(posedge clk) begin
    if (rst) begin
      m_sel = 0; m_ratio = 0; m_cnt = 0; m_base = 0;
      for (int b = 0; b < 4; b++) begin m_bcnt[b] = 0; m_btick[b] = 0; end
    end else begin
      for (int b = 0; b < 4; b++) begin
        if (!base_run_i || !br_gate_i[b]) begin
          m_bcnt[b] = 0; m_btick[b] = 0;
        end else if (m_base) begin
          if (m_bcnt[b] + 1 >= ratio_of(int'(br_code_i[b*4 +: 4]))) begin
            m_bcnt[b] = 0; m_btick[b] = 1;
          end else begin
            m_bcnt[b]++; m_btick[b] = 0;
          end
        end else m_btick[b] = 0;
      end
      if (!base_run_i) begin
        m_cnt = 0; m_base = 0;
        m_sel = int'(src_sel_i); m_ratio = int'(base_ratio_m1_i);
      end else if (pick(m_sel, src_en_i)) begin
        if (m_cnt == m_ratio) begin m_cnt = 0; m_base = 1; end
        else begin m_cnt++; m_base = 0; end
      end else m_base = 0;
    end
  end

  // compare, count ticks, drive sources: all away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({cur_tag, " R3 base tick"}, int'(base_tick_o), int'(m_base));
      for (int b = 0; b < 4; b++)
        chk({cur_tag, " R5 branch tick"}, int'(br_tick_o[b]), int'(m_btick[b]));
    end
    base_seen += int'(base_tick_o);
    for (int b = 0; b < 4; b++) br_seen[b] += int'(br_tick_o[b]);
    case (src_mode)
      0: src_en_i <= 6'h3f;
      1: src_en_i <= 6'($urandom);
      default: src_en_i <= 6'h10;
    endcase
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic clr();
    base_seen = 0;
    for (int b = 0; b < 4; b++) br_seen[b] = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++) br_seen[b] = 0;
    run(3);
    chk("R1 reset base", int'(base_tick_o), 0);
    chk("R1 reset branch", int'(br_tick_o), 0);
    rst = 1'b0;
    // R3/R5/R8: divide by 4 base, branches /1 /2 /12 and invalid code 9
    cur_tag = "R3";
    src_sel_i = 3'd0; base_ratio_m1_i = 8'd3;
    br_code_i = {4'd9, 4'd4, 4'd1, 4'd0}; br_gate_i = 4'hf;
    run(3);
    base_run_i = 1'b1; clr(); run(200);
    chk("R3 base count ratio 4", base_seen, 50);
    chk("R5 R8 encoder /1", br_seen[0], 49);
    chk("R5 R8 front end /2", br_seen[1], 24);
    chk("R5 R8 pixel pipe /12", br_seen[2], 4);
    chk("R5 R8 tx pixel code 9 as /1", br_seen[3], 49);
    // R4: changes while running are ignored
    cur_tag = "R4";
    src_sel_i = 3'd7; base_ratio_m1_i = 8'd0; clr(); run(40);
    chk("R4 running ignores sel/ratio", base_seen, 10);
    base_run_i = 1'b0; clr(); run(2);
    chk("R4 stopped quiet", base_seen, 0);
    chk("R7 branches quiet when stopped", br_seen[0], 0);
    // R2: code 7 selects nothing
    cur_tag = "R2";
    base_run_i = 1'b1; clr(); run(30);
    chk("R2 code 7 no source", base_seen, 0);
    // R2: alias code 6 picks source 4
    base_run_i = 1'b0; src_sel_i = 3'd6; src_mode = 2; run(2);
    base_run_i = 1'b1; clr(); run(20);
    chk("R2 code 6 picks source 4", base_seen, 20);
    base_run_i = 1'b0; src_sel_i = 3'd0; run(2);
    base_run_i = 1'b1; clr(); run(20);
    chk("R2 code 0 ignores source 4", base_seen, 0);
    // random sources, every select, varied ratios, codes and gates
    cur_tag = "R2 random";
    src_mode = 1;
    for (int s = 0; s < 8; s++) begin
      base_run_i = 1'b0; src_sel_i = 3'(s); base_ratio_m1_i = 8'(s % 3);
      br_code_i = 16'($urandom); br_gate_i = 4'($urandom) | 4'h1;
      run(2);
      base_run_i = 1'b1; run(150);
      br_code_i = 16'($urandom); run(50);
    end
    // R6: gate off the pixel pipe
    cur_tag = "R6";
    src_mode = 0; base_run_i = 1'b0; src_sel_i = 3'd0; base_ratio_m1_i = 8'd0;
    br_code_i = 16'h0000; br_gate_i = 4'b1011; run(2);
    base_run_i = 1'b1; clr(); run(30);
    chk("R6 gated branch silent", br_seen[2], 0);
    chk("R6 other branch runs", br_seen[0], 29);
    br_gate_i = 4'hf; clr(); run(10);
    chk("R6 branch resumes", br_seen[2], 10);
    // R7: short stop clears a half-finished branch count
    cur_tag = "R7";
    base_run_i = 1'b0; br_code_i = {4'd0, 4'd0, 4'd4, 4'd0}; run(2);
    base_run_i = 1'b1; run(5);
    base_run_i = 1'b0; run(1);
    base_run_i = 1'b1; clr(); run(11);
    chk("R7 front end restarted from zero", br_seen[1], 0);
    chk("R7 encoder after restart", br_seen[0], 10);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule